// File: doc/BRIEF.md
# Descriptor-Chain DMA Engine

This block moves data between a byte-wide device port and a 32-bit memory port. It does not take one buffer from software. It reads a chain of descriptors from memory. Each descriptor is 16 bytes and names one buffer address and one length. Software fills in a small register file: the chain base, a completion-marker address and the direction. It then sets the start bit. The engine fetches the descriptors one at a time and streams each buffer word by word. It stops after the descriptor that carries the end-of-list flag.

When a run ends, whether it drained normally or was halted on request, the engine writes a block of all-ones words to the completion-marker area. Software can poll that memory instead of the registers. The marker therefore shows that the data writes have reached memory even when register reads can overtake DMA writes. A memory error response aborts the run at once. It sets a sticky error flag and drives a bus-error interrupt line.

Top module: `dchain_dma`

## Requirements
- R1: After reset every register reads zero, the engine is idle, and mem_req, dev_in_ready, dev_out_valid and irq_buserr are low.
- R2: Registers are addressed by word index. Index 0 is a free scratch/timing word and 8 is the marker address; both read back as written. Index 1 is the chain base and 2 its high word, both read back. Index 3 is the current buffer address and 4 reads zero. Index 5 counts device bytes and 6 counts memory bytes. Index 7 is control/status with bit0 start, bit1 stop, bit2 direction, bit3 active and bit4 error.
- R3: Writing index 7 with bit0 set while idle does five things: it latches the chain base, clears both byte counters and the error flag, takes the direction from bit2 and sets active. Start reads back as 0. A start written while active is ignored and does not clear the counters.
- R4: For each descriptor at pointer P, the engine reads P+4 as the buffer address and P+12 as the length word. In the length word, bits 15:0 are the byte length (bits 1:0 ignored) and bit31 is end-of-list. The next descriptor is at P+16. No descriptor after an end-of-list one is fetched.
- R5: With direction 1, device bytes are packed four to a word, the first byte in bits 7:0. The words are written to consecutive addresses from the buffer address. Each byte adds 1 to the device count and each word adds 4 to the memory count.
- R6: With direction 0, words are read from the buffer and sent on the device port lowest byte first. The counters advance as in R5.
- R7: At the end of a run the engine writes MARK_WORDS words of 0xFFFFFFFF to consecutive addresses from the marker address. Active clears only after the last of them.
- R8: A stop written while active reads back as 1 until the engine has halted at a word boundary and written the marker block. It then reads 0 with active cleared. A stop written while idle reads 0.
- R9: A memory error response sets error, clears active and stop, and drops mem_req on the next cycle with no marker block written. irq_buserr stays high until the next start.
- R10: A memory request keeps mem_req, mem_addr and mem_we stable until mem_rvalid is seen.
- R11: A descriptor whose length is below 4 moves no data, and the chain moves on to the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request, held until response |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Response for the pending request |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rdata | input | 32 | Read data |
| dev_in_valid | input | 1 | Device offers a byte |
| dev_in_data | input | 8 | Device byte |
| dev_in_ready | output | 1 | Engine accepts a device byte |
| dev_out_valid | output | 1 | Engine offers a byte to the device |
| dev_out_data | output | 8 | Byte to the device |
| dev_out_ready | input | 1 | Device accepts the byte |
| irq_buserr | output | 1 | Memory error interrupt, level |

## Verification
Two events can meet in the same cycle: a stop request from software and the engine's own decision about where to go after a word or a descriptor. Both want to choose the next action. The bench provokes the meeting by starting a run with the device stalled, so the engine waits at a word boundary, and then writing stop. It judges the result from the status bits, from the byte counters staying at zero and from the marker block in memory. A start written during a running transfer is also checked, through counters that must keep counting instead of restarting.

// File: rtl/dchain_dma.sv
module dchain_dma #(
  parameter int MARK_WORDS = 32,
  parameter int LEN_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic        mem_rsp_err,
  input  logic [31:0] mem_rdata,
  input  logic        dev_in_valid,
  input  logic [7:0]  dev_in_data,
  output logic        dev_in_ready,
  output logic        dev_out_valid,
  output logic [7:0]  dev_out_data,
  input  logic        dev_out_ready,
  output logic        irq_buserr
);
  localparam int MI_W = (MARK_WORDS > 1) ? $clog2(MARK_WORDS) : 1;

  typedef enum logic [3:0] {S_IDLE, S_FA, S_FL, S_NXT, S_DIN, S_MWR, S_MRD, S_DOUT, S_MARK} st_t;
  st_t st;

  logic [31:0] tmg, ptr_lo, ptr_hi, mark, walk, cur, dcnt, mcnt, wbuf;
  logic [LEN_W-1:0] rem;
  logic [MI_W-1:0]  mi;
  logic [1:0] bi;
  logic dir, stop_p, err, eol;

  wire active = (st != S_IDLE);
  wire ok     = mem_rvalid & ~mem_rsp_err;
  wire bad    = mem_rvalid &  mem_rsp_err;
  wire go     = reg_wr && reg_addr == 4'd7 && reg_wdata[0] && !active;
  wire hold   = stop_p && bi == 2'd0;

  assign mem_req       = st inside {S_FA, S_FL, S_MWR, S_MRD, S_MARK};
  assign mem_we        = st inside {S_MWR, S_MARK};
  assign mem_wdata     = (st == S_MARK) ? '1 : (st == S_MWR) ? wbuf : '0;
  assign dev_in_ready  = (st == S_DIN) && !hold;
  assign dev_out_valid = (st == S_DOUT);
  assign dev_out_data  = wbuf[{bi, 3'b000} +: 8];
  assign irq_buserr    = err;

  always_comb begin
    case (st)
      S_FA:         mem_addr = walk + 32'd4;
      S_FL:         mem_addr = walk + 32'd12;
      S_MWR, S_MRD: mem_addr = cur;
      S_MARK:       mem_addr = mark + 32'({mi, 2'b00});
      default:      mem_addr = '0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = tmg;
      4'd1:    reg_rdata = ptr_lo;
      4'd2:    reg_rdata = ptr_hi;
      4'd3:    reg_rdata = cur;
      4'd5:    reg_rdata = dcnt;
      4'd6:    reg_rdata = mcnt;
      4'd7:    reg_rdata = {27'd0, err, active, dir, stop_p, 1'b0};
      4'd8:    reg_rdata = mark;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tmg <= '0; ptr_lo <= '0; ptr_hi <= '0; mark <= '0; walk <= '0;
      cur <= '0; dcnt <= '0; mcnt <= '0; wbuf <= '0; rem <= '0;
      mi <= '0; bi <= '0; dir <= 1'b0; stop_p <= 1'b0; err <= 1'b0; eol <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          4'd0: tmg    <= reg_wdata;
          4'd1: ptr_lo <= reg_wdata;
          4'd2: ptr_hi <= reg_wdata;
          4'd8: mark   <= reg_wdata;
          4'd7: begin
            if (!active) dir <= reg_wdata[2];
            if (active && reg_wdata[1]) stop_p <= 1'b1;
          end
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (go) begin
          walk <= ptr_lo; dcnt <= '0; mcnt <= '0; err <= 1'b0; mi <= '0;
          st <= S_FA;
        end
        S_FA: if (bad) begin
          err <= 1'b1; stop_p <= 1'b0; st <= S_IDLE;
        end else if (ok) begin
          cur <= mem_rdata;
          st  <= stop_p ? S_MARK : S_FL;
        end
        S_FL: if (bad) begin
          err <= 1'b1; stop_p <= 1'b0; st <= S_IDLE;
        end else if (ok) begin
          rem <= {mem_rdata[LEN_W-1:2], 2'b00};
          eol <= mem_rdata[31];
          bi  <= '0;
          if (mem_rdata[LEN_W-1:2] == '0) st <= S_NXT;
          else st <= dir ? S_DIN : S_MRD;
        end
        S_NXT: if (eol || stop_p) st <= S_MARK;
          else begin walk <= walk + 32'd16; st <= S_FA; end
        S_DIN: if (hold) st <= S_MARK;
          else if (dev_in_valid) begin
            wbuf[{bi, 3'b000} +: 8] <= dev_in_data;
            dcnt <= dcnt + 32'd1;
            bi   <= bi + 2'd1;
            if (bi == 2'd3) st <= S_MWR;
          end
        S_MWR: if (bad) begin
          err <= 1'b1; stop_p <= 1'b0; st <= S_IDLE;
        end else if (ok) begin
          mcnt <= mcnt + 32'd4; cur <= cur + 32'd4; rem <= rem - LEN_W'(4);
          if (stop_p) st <= S_MARK;
          else st <= (rem == LEN_W'(4)) ? S_NXT : S_DIN;
        end
        S_MRD: if (bad) begin
          err <= 1'b1; stop_p <= 1'b0; st <= S_IDLE;
        end else if (ok) begin
          wbuf <= mem_rdata; bi <= '0;
          mcnt <= mcnt + 32'd4; cur <= cur + 32'd4; rem <= rem - LEN_W'(4);
          st <= S_DOUT;
        end
        S_DOUT: if (dev_out_ready) begin
          dcnt <= dcnt + 32'd1;
          bi   <= bi + 2'd1;
          if (bi == 2'd3) begin
            if (stop_p) st <= S_MARK;
            else st <= (rem == '0) ? S_NXT : S_MRD;
          end
        end
        S_MARK: if (bad) begin
          err <= 1'b1; stop_p <= 1'b0; st <= S_IDLE;
        end else if (ok) begin
          if (mi == MI_W'(MARK_WORDS - 1)) begin
            st <= S_IDLE; stop_p <= 1'b0;
          end else mi <= mi + MI_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dchain_dma_chk.sv
module dchain_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        mem_rsp_err,
  input logic        dev_in_ready,
  input logic        dev_out_valid,
  input logic        irq_buserr
);
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r9_halt_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid && mem_rsp_err |=> !mem_req && irq_buserr);

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_buserr) |-> $past(mem_rvalid && mem_rsp_err));

  a_r5_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_in_ready && dev_out_valid));
endmodule

bind dchain_dma dchain_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rsp_err(mem_rsp_err),
  .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
  .irq_buserr(irq_buserr)
);

// File: tb/sim_dchain_dma.sv
module sim_dchain_dma;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_rvalid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic dev_in_ready, dev_out_valid, irq_buserr;
  logic [7:0] dev_out_data, dev_in_data;
  logic src_en = 1'b0;
  logic [31:0] src_idx = '0, sink_n = '0, bad_fetch = '0;
  logic [31:0] err_addr = 32'hFFFF_FFF0;
  logic [31:0] mem [0:255];
  logic [7:0] sink [0:255];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dev_in_data = 8'(32'h10 + src_idx);

  dchain_dma u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rsp_err(mem_rsp_err), .mem_rdata(mem_rdata),
    .dev_in_valid(src_en), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
    .dev_out_ready(1'b1), .irq_buserr(irq_buserr)
  );

  always @(posedge clk) begin
    if (!rst_n) mem_rvalid <= 1'b0;
    else if (mem_rvalid) mem_rvalid <= 1'b0;
    else if (mem_req) begin
      mem_rvalid  <= 1'b1;
      mem_rsp_err <= (mem_addr == err_addr);
      mem_rdata   <= mem[mem_addr[9:2]];
      if (mem_we && mem_addr != err_addr) mem[mem_addr[9:2]] <= mem_wdata;
      if (!mem_we && mem_addr >= 32'h20 && mem_addr < 32'h30) bad_fetch <= bad_fetch + 1;
    end
    if (src_en && dev_in_ready) src_idx <= src_idx + 1;
    if (dev_out_valid) begin
      sink[sink_n[7:0]] <= dev_out_data;
      sink_n <= sink_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(4'd7, v);
      if (!v[3]) return;
    end
    chk("R7 engine went idle", 32'd0, 32'd1);
  endtask

  task automatic set_desc(input int b, input logic [31:0] a, input logic [15:0] len, input bit e);
    mem[b/4] = 0; mem[b/4+1] = a; mem[b/4+2] = 0; mem[b/4+3] = {e, 15'd0, len};
  endtask

  task automatic clr_mark();
    for (int w = 192; w < 224; w++) mem[w] = 0;
  endtask

  function automatic int mark_ones();
    int n = 0;
    for (int w = 192; w < 224; w++) if (mem[w] == 32'hFFFF_FFFF) n++;
    return n;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      chk("R1 register reset value", v, 0);
    end
    chk("R1 outputs idle", {mem_req, dev_in_ready, dev_out_valid, irq_buserr}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(4'd0, 32'hA5A5_0001); wr(4'd2, 32'h0000_0077); wr(4'd8, 32'h300);
    rd(4'd0, v); chk("R2 timing readback", v, 32'hA5A5_0001);
    rd(4'd2, v); chk("R2 pointer high readback", v, 32'h77);
    rd(4'd8, v); chk("R2 marker readback", v, 32'h300);
    rd(4'd4, v); chk("R2 index 4 reads zero", v, 0);
    wr(4'd7, 32'h2);
    rd(4'd7, v); chk("R8 stop while idle reads 0", v, 0);
  endtask

  task automatic t_dev_to_mem();
    logic [31:0] v, s0;
    set_desc(32'h00, 32'h100, 16'd8, 0);
    set_desc(32'h10, 32'h180, 16'd4, 1);
    set_desc(32'h20, 32'h1C0, 16'd4, 0);
    mem[32'h1C0/4] = 32'hDEAD_BEEF;
    clr_mark();
    s0 = src_idx; src_en = 1'b1;
    wr(4'd1, 32'h0);
    wr(4'd7, 32'h5);
    rd(4'd7, v); chk("R3 active set, start reads 0", v & 32'h1F, 32'h0C);
    repeat (6) @(negedge clk);
    wr(4'd1, 32'h40);
    wr(4'd7, 32'h5);
    wait_idle();
    src_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      logic [31:0] e;
      for (int j = 0; j < 4; j++) e[8*j +: 8] = 8'(32'h10 + s0 + 4*k + j);
      chk("R5 packed word in memory", mem[(k < 2) ? (32'h100/4 + k) : 32'h180/4], e);
    end
    chk("R4 descriptor after end-of-list untouched", mem[32'h1C0/4], 32'hDEAD_BEEF);
    chk("R4 no fetch past end-of-list", bad_fetch, 0);
    rd(4'd5, v); chk("R3 R5 device count not restarted", v, 12);
    rd(4'd6, v); chk("R5 memory count", v, 12);
    rd(4'd3, v); chk("R4 current address", v, 32'h184);
    chk("R7 marker block all ones", mark_ones(), 32);
    rd(4'd7, v); chk("R7 status after run", v, 32'h04);
  endtask

  task automatic t_mem_to_dev();
    logic [31:0] v, n0;
    set_desc(32'h40, 32'h200, 16'd8, 1);
    mem[32'h200/4] = 32'h4433_2211; mem[32'h204/4] = 32'h8877_6655;
    clr_mark();
    n0 = sink_n;
    wr(4'd1, 32'h40);
    wr(4'd7, 32'h1);
    wait_idle();
    chk("R6 byte count at device", sink_n - n0, 8);
    for (int k = 0; k < 8; k++) chk("R6 byte order", sink[8'(n0 + k)], 8'(8'h11 * (k + 1)));
    rd(4'd5, v); chk("R6 device count", v, 8);
    rd(4'd6, v); chk("R6 memory count", v, 8);
    chk("R7 marker after read run", mark_ones(), 32);
  endtask

  task automatic t_zero_len();
    logic [31:0] v, n0;
    set_desc(32'h60, 32'h240, 16'd0, 0);
    set_desc(32'h70, 32'h244, 16'd4, 1);
    mem[32'h240/4] = 32'h1111_1111; mem[32'h244/4] = 32'hDDCC_BBAA;
    n0 = sink_n;
    wr(4'd1, 32'h60);
    wr(4'd7, 32'h1);
    wait_idle();
    chk("R11 only second buffer sent", sink_n - n0, 4);
    chk("R11 first byte from second buffer", sink[8'(n0)], 8'hAA);
    rd(4'd6, v); chk("R11 memory count", v, 4);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    set_desc(32'h80, 32'h280, 16'd64, 1);
    clr_mark();
    src_en = 1'b0;
    wr(4'd1, 32'h80);
    wr(4'd7, 32'h5);
    repeat (10) @(negedge clk);
    wr(4'd7, 32'h6);
    rd(4'd7, v); chk("R8 stop pending reads 1", v, 32'h0E);
    wait_idle();
    rd(4'd7, v); chk("R8 stop and active cleared", v, 32'h04);
    rd(4'd5, v); chk("R8 no bytes moved", v, 0);
    chk("R8 marker written on stop", mark_ones(), 32);
  endtask

  task automatic t_error();
    logic [31:0] v;
    set_desc(32'hA0, 32'h2C0, 16'd4, 1);
    clr_mark();
    err_addr = 32'h2C0; src_en = 1'b1;
    wr(4'd1, 32'hA0);
    wr(4'd7, 32'h5);
    wait_idle();
    src_en = 1'b0;
    rd(4'd7, v); chk("R9 error set, active clear", v, 32'h14);
    chk("R9 irq raised", irq_buserr, 1);
    chk("R9 no marker after error", mark_ones(), 0);
    err_addr = 32'hFFFF_FFF0;
    wr(4'd1, 32'h40);
    wr(4'd7, 32'h1);
    chk("R9 irq cleared by start", irq_buserr, 0);
    wait_idle();
    rd(4'd7, v); chk("R9 error cleared by start", v, 0);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int w = 0; w < 256; w++) mem[w] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_dev_to_mem();
    t_mem_to_dev();
    t_zero_len();
    t_stop();
    t_error();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule